// File: doc/BRIEF.md
# Power-down entry and wake-up sequencer

This block steers a chip into and back out of its deep power-down state. Software arms the transition through a protected control register. The chip stops only when the processor also reports that it is asleep. While the chip is down, the two fast oscillators are held off, the PLL is forced into its own power-down, and the system clock is gated. The two slow oscillators keep whatever enable state software gave them.

A wake-up event brings the fast oscillators back and clears the arm bit. Software must therefore arm the block again before the next power-down. An optional settling delay keeps the system clock gated for a while after wake. The length of that delay depends on which fast oscillator feeds the system clock. Every wake sets a sticky status flag, which software clears by writing 1 to it. That flag, combined with its enable bit, drives the wake-up interrupt.

The control register is 9 bits wide and is read back zero-extended on `rd_data`:
- bit 0: fast crystal enable
- bit 1: fast RC enable
- bit 2: slow crystal enable
- bit 3: slow RC enable
- bit 4: PLL off
- bit 5: settle-delay enable
- bit 6: interrupt enable
- bit 7: arm
- bit 8: wake flag

Top module: `pd_wake_seq`

## Requirements
- R1: With the arm bit (bit 7) set, the block waits in an armed state and keeps `clk_en` high while `cpu_sleep` is low. Power-down begins on the first clock edge in the armed state at which `cpu_sleep` is high. The armed state itself is entered on the edge after the arm bit becomes 1.
- R2: The wake edge clears the arm bit (bit 7) to 0.
- R3: During power-down, `osc_fast_en` is 2'b00, whatever bits 0 and 1 hold. `osc_slow_en` keeps following bits 3:2.
- R4: During power-down, `pll_pd` is 1 and `clk_en` is 0, whatever `sel_src` is. Outside power-down, `pll_pd` equals bit 4.
- R5: This applies when bit 5 is 1 at the wake edge. If `sel_src` is 2'b00 (fast crystal), `clk_en` stays 0 for EXT_SETTLE cycles (default 4096) after that edge. If `sel_src` is 2'b01 (fast RC), it stays 0 for RC_SETTLE cycles (default 256). In both cases `osc_fast_en` returns to bits 1:0 right after the wake edge.
- R6: This applies when bit 5 is 0, or when `sel_src` is 2'b10 (PLL) or 2'b11 (slow source). `clk_en` is 1 in the cycle right after the wake edge.
- R7: A wake event during power-down sets the flag (bit 8). A write with `wr_data[8]`=1 clears it. If both happen on the same edge, the set wins.
- R8: `wake_irq` is 1 exactly while bit 8 and bit 6 are both 1.
- R9: Bits 7:0 take `wr_data[7:0]` on a write only while `reg_unlock` is 1. Without the unlock they keep their value, but the flag clear of R7 still works.
- R10: A wake event while armed but not yet asleep changes nothing: the flag stays, the arm bit stays, and `clk_en` stays 1.
- R11: After reset, `rd_data` reads 0x012 (fast RC on, PLL off). `osc_fast_en` is 2'b10, `clk_en` is 1 and `wake_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sleep | input | 1 | Processor sleep indication |
| wake_evt | input | 1 | Wake-up event pulse from the wake-source logic |
| sel_src | input | 2 | System clock source: 0 fast crystal, 1 fast RC, 2 PLL, 3 slow |
| reg_unlock | input | 1 | Write-protection open when 1 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Register read data, zero-extended |
| osc_fast_en | output | 2 | Fast oscillator enables (bit 0 crystal, bit 1 RC) |
| osc_slow_en | output | 2 | Slow oscillator enables (bit 0 crystal, bit 1 RC) |
| pll_pd | output | 1 | PLL power-down request |
| clk_en | output | 1 | System clock gate, 1 lets the clock run |
| wake_irq | output | 1 | Wake-up interrupt |

## Verification
The assertions assume that `wake_evt` is a pulse that matters only while the chip is down or armed. They also assume that `sel_src` holds steady across the wake edge, because the settle length is sampled on that edge. The stimulus respects both assumptions. It raises `cpu_sleep` only after arming, pulses `wake_evt` for one cycle, and changes `sel_src` only while the clock is running. Random register traffic mixes locked and unlocked writes, with the arm bit sometimes set, so that write protection, flag clearing and the arm and disarm paths all meet each other.

// File: rtl/pd_wake_pkg.sv
package pd_wake_pkg;
   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_ARMED  = 2'd1,
      ST_DOWN   = 2'd2,
      ST_SETTLE = 2'd3
   } pd_state_e;

   // bit 0 is the last member
   typedef struct packed {
      logic flag;
      logic arm;
      logic irq_en;
      logic dly_en;
      logic pll_off;
      logic slow_rc_en;
      logic slow_xt_en;
      logic fast_rc_en;
      logic fast_xt_en;
   } pd_ctrl_t;

   localparam int CTRL_W = $bits(pd_ctrl_t);
   localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h012;

   localparam logic [1:0] SRC_FAST_XT = 2'd0;
   localparam logic [1:0] SRC_FAST_RC = 2'd1;
endpackage

// File: rtl/pd_ctrl_regs.sv
module pd_ctrl_regs
   import pd_wake_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              reg_unlock,
   input  logic              wake_hit,
   output pd_ctrl_t          ctrl_q
);
   pd_ctrl_t ctrl_d;

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr_en && reg_unlock)
         ctrl_d = pd_ctrl_t'({ctrl_q.flag, wr_data[CTRL_W-2:0]});
      if (wr_en && wr_data[CTRL_W-1])
         ctrl_d.flag = 1'b0;
      if (wake_hit) begin
         ctrl_d.flag = 1'b1;
         ctrl_d.arm  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= pd_ctrl_t'(CTRL_RESET);
      else        ctrl_q <= ctrl_d;
   end

   assert_wake_clears_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wake_hit |=> (!ctrl_q.arm && ctrl_q.flag));

   assert_flag_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_hit && wr_en && wr_data[CTRL_W-1]) |=> ctrl_q.flag);

   assert_locked_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !reg_unlock) |=> $stable(ctrl_q[CTRL_W-3:0]));
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
   import pd_wake_pkg::*;
#(
   parameter int EXT_SETTLE = 4096,
   parameter int RC_SETTLE  = 256
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      arm,
   input  logic      dly_en,
   input  logic      cpu_sleep,
   input  logic      wake_evt,
   input  logic [1:0] sel_src,
   output pd_state_e state_q,
   output logic      wake_hit
);
   localparam int MAX_SETTLE = (EXT_SETTLE > RC_SETTLE) ? EXT_SETTLE : RC_SETTLE;
   localparam int CNT_W      = (MAX_SETTLE > 2) ? $clog2(MAX_SETTLE) : 1;
   localparam logic [CNT_W-1:0] XT_LOAD = CNT_W'(EXT_SETTLE - 1);
   localparam logic [CNT_W-1:0] RC_LOAD = CNT_W'(RC_SETTLE - 1);

   pd_state_e        state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             need_settle;

   assign wake_hit    = (state_q == ST_DOWN) && wake_evt;
   assign need_settle = dly_en && ((sel_src == SRC_FAST_XT) || (sel_src == SRC_FAST_RC));

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_RUN:    if (arm) state_d = ST_ARMED;
         ST_ARMED: begin
            if (!arm)           state_d = ST_RUN;
            else if (cpu_sleep) state_d = ST_DOWN;
         end
         ST_DOWN: begin
            if (wake_evt) begin
               if (need_settle) begin
                  state_d = ST_SETTLE;
                  cnt_d   = (sel_src == SRC_FAST_XT) ? XT_LOAD : RC_LOAD;
               end else begin
                  state_d = ST_RUN;
               end
            end
         end
         ST_SETTLE: begin
            if (cnt_q == '0) state_d = ST_RUN;
            else             cnt_d   = cnt_q - 1'b1;
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assert_no_down_while_awake_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARMED && !cpu_sleep) |=> (state_q != ST_DOWN));

   assert_settle_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETTLE) |-> (int'(cnt_q) < MAX_SETTLE));

   assert_armed_ignores_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARMED && arm && !cpu_sleep) |=> (state_q != ST_DOWN && state_q != ST_SETTLE));
endmodule

// File: rtl/pd_wake_seq.sv
module pd_wake_seq
   import pd_wake_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int EXT_SETTLE = 4096,
   parameter int RC_SETTLE  = 256,
   parameter int N_FAST     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sleep,
   input  logic              wake_evt,
   input  logic [1:0]        sel_src,
   input  logic              reg_unlock,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        osc_fast_en,
   output logic [1:0]        osc_slow_en,
   output logic              pll_pd,
   output logic              clk_en,
   output logic              wake_irq
);
   if (DATA_W < CTRL_W) begin : g_bad_width
      $error("DATA_W must hold the control register");
   end
   if (EXT_SETTLE < 1 || RC_SETTLE < 1) begin : g_bad_settle
      $error("settle counts must be at least 1");
   end
   if (N_FAST != 2) begin : g_bad_fast
      $error("exactly two fast oscillators are sequenced");
   end

   pd_ctrl_t  ctrl;
   pd_state_e state;
   logic      wake_hit;
   logic      in_down;
   logic [N_FAST-1:0] fast_sw;

   pd_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .reg_unlock(reg_unlock), .wake_hit(wake_hit), .ctrl_q(ctrl)
   );

   pd_fsm #(.EXT_SETTLE(EXT_SETTLE), .RC_SETTLE(RC_SETTLE)) u_fsm (
      .clk(clk), .rst_n(rst_n), .arm(ctrl.arm), .dly_en(ctrl.dly_en),
      .cpu_sleep(cpu_sleep), .wake_evt(wake_evt), .sel_src(sel_src),
      .state_q(state), .wake_hit(wake_hit)
   );

   assign in_down = (state == ST_DOWN);
   assign fast_sw = {ctrl.fast_rc_en, ctrl.fast_xt_en};

   for (genvar g = 0; g < N_FAST; g++) begin : g_fast_gate
      assign osc_fast_en[g] = fast_sw[g] && !in_down;
   end

   assign osc_slow_en = {ctrl.slow_rc_en, ctrl.slow_xt_en};
   assign pll_pd      = ctrl.pll_off || in_down;
   assign clk_en      = (state == ST_RUN) || (state == ST_ARMED);
   assign wake_irq    = ctrl.flag && ctrl.irq_en;
   assign rd_data     = DATA_W'(ctrl);

   assert_fast_off_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_down |-> (osc_fast_en == 2'b00 && osc_slow_en == rd_data[3:2]));

   assert_pll_clk_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_down |-> (pll_pd && !clk_en));

   assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> (rd_data[8] && rd_data[6]));

   assert_clk_back_no_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_hit && !rd_data[5]) |=> clk_en);
endmodule

// File: tb/test_pd_wake_seq.sv
module test_pd_wake_seq;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_sleep = 1'b0, wake_evt = 1'b0, reg_unlock = 1'b0, wr_en = 1'b0;
   logic [1:0]    sel_src = 2'd1;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [1:0]    osc_fast_en, osc_slow_en;
   logic          pll_pd, clk_en, wake_irq;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 0;
   logic [8:0] m;   // model of the control register

   always #10 clk = ~clk;   // 50 MHz

   pd_wake_seq i_pd_wake_seq (
      .clk(clk), .rst_n(rst_n), .cpu_sleep(cpu_sleep), .wake_evt(wake_evt),
      .sel_src(sel_src), .reg_unlock(reg_unlock), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .osc_fast_en(osc_fast_en), .osc_slow_en(osc_slow_en),
      .pll_pd(pll_pd), .clk_en(clk_en), .wake_irq(wake_irq)
   );

   function automatic logic [8:0] model_write(logic [8:0] cur, logic [8:0] d, bit unl);
      logic [8:0] r = cur;
      if (unl)  r[7:0] = d[7:0];
      if (d[8]) r[8]   = 1'b0;
      return r;
   endfunction

   function automatic int exp_gate(logic [1:0] src, bit dly);
      if (!dly)        return 0;
      if (src == 2'd0) return 4096;
      if (src == 2'd1) return 256;
      return 0;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(logic [8:0] d, bit unl);
      wr_en = 1'b1; wr_data = DW'(d); reg_unlock = unl;
      cyc();
      wr_en = 1'b0; reg_unlock = 1'b0;
      m = model_write(m, d, unl);
   endtask

   task automatic run_wake(logic [1:0] src, bit dly, bit ien);
      int n;
      sel_src = src;
      wr({1'b0, 1'b1, ien, dly, m[4:0]}, 1'b1);
      repeat (4) cyc();
      chk("R1 armed clock runs", clk_en, 1);
      cpu_sleep = 1'b1;
      cyc();
      chk("R1 down after sleep", clk_en, 0);
      cyc();
      chk("R3 fast osc off", osc_fast_en, 0);
      chk("R3 slow osc kept", osc_slow_en, m[3:2]);
      chk("R4 pll down", pll_pd, 1);
      wake_evt = 1'b1;
      cyc();
      wake_evt = 1'b0; cpu_sleep = 1'b0;
      chk("R5 fast osc restored", osc_fast_en, m[1:0]);
      n = 0;
      while (!clk_en && n < 10000) begin n++; cyc(); end
      chk((exp_gate(src, dly) == 0) ? "R6 gate cycles" : "R5 gate cycles", n, exp_gate(src, dly));
      m[7] = 1'b0; m[8] = 1'b1;
      chk("R2 R7 arm clear flag set", rd_data, m);
      chk("R8 irq", wake_irq, ien);
      chk("R4 pll after wake", pll_pd, m[4]);
   endtask

   initial begin
      m = 9'h012;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      chk("R11 reset reg", rd_data, 16'h012);
      chk("R11 reset fast", osc_fast_en, 2'b10);
      chk("R11 reset clk", clk_en, 1);
      chk("R11 reset irq", wake_irq, 0);
      chk("R4 reset pll", pll_pd, 1);

      // R9 locked write is ignored
      wr(9'h0FF, 1'b0);
      chk("R9 locked write", rd_data, 16'h012);
      wr(9'h00D, 1'b1);
      chk("R9 unlocked write", rd_data, m);

      // R10 wake while armed but awake
      wr(9'h08D, 1'b1);
      repeat (3) cyc();
      wake_evt = 1'b1; cyc(); wake_evt = 1'b0;
      cyc();
      chk("R10 flag unchanged", rd_data[8], 0);
      chk("R10 arm kept", rd_data[7], 1);
      chk("R10 clock runs", clk_en, 1);
      wr(9'h00D, 1'b1);

      // directed settle cases
      run_wake(2'd0, 1'b1, 1'b1);
      run_wake(2'd1, 1'b1, 1'b0);
      run_wake(2'd2, 1'b1, 1'b1);
      run_wake(2'd0, 1'b0, 1'b1);

      // R7 and R9: flag clear while locked
      chk("R8 irq before clear", wake_irq, 1);
      wr(9'h100, 1'b0);
      chk("R7 flag cleared locked", rd_data, m);
      chk("R8 irq after clear", wake_irq, 0);

      // random register traffic
      void'($urandom(32'h5EED));
      for (int i = 0; i < 60; i++) begin
         logic [8:0] d = 9'($urandom);
         wr(d, 1'($urandom));
         chk("R9 random write", rd_data, m);
         chk("R8 random irq", wake_irq, m[8] & m[6]);
      end
      wr({1'b1, 8'h0F}, 1'b1);
      cyc();

      // random wake runs
      for (int i = 0; i < 8; i++) begin
         run_wake(2'($urandom), 1'($urandom), 1'($urandom));
         wr(9'h100 | {1'b0, 8'($urandom) & 8'h1F}, 1'b1);
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule